// File: doc/BRIEF.md
# Data-Write Loaded Program Bank Register

This block lets a processor with a 16-bit address space reach a larger program memory without giving up any port pins for bank control. Software picks a program bank by doing an ordinary external data write anywhere in the top 32 bytes of data space. The low four bits of the write data are kept as the bank number. The block drives that number onto the upper address lines of the program memory.

The lower half of the 16-bit space is a common area. It holds the reset and interrupt vectors and the service routines. While the processor addresses that half, the upper memory address lines are held at zero, but the stored bank number is left alone. When execution returns to the upper half, the previously selected bank appears on the outputs again with no further write. The 32 data locations used for the window cannot be used as ordinary data.

Top module: `bank_switch_latch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored bank is cleared to 0. After reset, `page_addr` reads 0 even when `cpu_addr_hi` bit 10 (A15) is 1.
- R2: A qualified write loads `cpu_wdata` into the stored bank at the rising clock edge where it is sampled. A qualified write is `cpu_wr_n` low with all eleven `cpu_addr_hi` bits (A15..A5) equal to 1, which covers FFE0h–FFFFh.
- R3: A write with `cpu_wr_n` low, where any `cpu_addr_hi` bit is 0, leaves the stored bank unchanged.
- R4: While `cpu_addr_hi` bit 10 (A15) is 0, so the address is in 0000h–7FFFh, `page_addr` is 0 in the same cycle, and the stored bank is not altered.
- R5: While `cpu_addr_hi` bit 10 is 1, so the address is in 8000h–FFFFh, `page_addr` equals the stored bank in the same cycle. The bank is therefore restored after a common-area access with no new write.
- R6: With `cpu_wr_n` high, an address inside the window changes nothing, whatever the value of `cpu_wdata`.
- R7: With no qualified write, the stored bank keeps its value over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bank register samples on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr_hi | input | 11 | Processor address bits A15..A5; bit 10 is A15 |
| cpu_wdata | input | 4 | Processor data bits D3..D0 |
| cpu_wr_n | input | 1 | Active-low data write strobe |
| page_addr | output | 4 | Program memory address bits A18..A15; bit 3 is A18 |

## Verification
The hardest situation to reach from the ports is a common-area access that falls between a bank load and a later paged access. Only that sequence shows that the register kept its value while its outputs were forced to zero.

The vector table loads a bank, visits 0000h–7FFFh with the strobe both high and low, and then returns to the upper half. The check there expects the earlier bank, not zero. It also needs writes that miss the window by one address bit (A5 or A15), which must leave the bank unchanged. A bank value of 0 is loaded as well, so that a restore is not confused with a reset.

// File: rtl/bank_switch_pkg.sv
// Package: shared sizes and a helper for the bank switch latch.
// Assumes: the window is the block of data addresses whose upper bits are all one.
package bank_switch_pkg;
    localparam int DEF_ADDR_HI_W = 11;  // address bits A15..A5
    localparam int DEF_BANK_W    = 4;   // bank number bits

    // Returns 1 when every bit of the given upper address field is one.
    function automatic logic window_hit(input logic [DEF_ADDR_HI_W-1:0] a);
        return &a;
    endfunction
endpackage

// File: rtl/bank_window_decode.sv
// Decoder: turns the address match and the write strobe into a one-cycle load enable.
// Assumes: the strobe is sampled synchronously, and any cycle with the strobe low and
// every upper address bit set counts as a bank write.
module bank_window_decode #(
    parameter int ADDR_HI_W = 11
) (
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic                 wr_n,
    output logic                 load_en
);
    // Qualify the active-low strobe with an all-ones address match.
    always_comb begin
        load_en = (&addr_hi) & ~wr_n;
    end
endmodule

// File: rtl/bank_hold_reg.sv
// Register: holds the bank number and loads it only when the load enable is set.
// Assumes: synchronous active-low reset clears it to bank 0.
module bank_hold_reg #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q
);
    // Clear on reset, capture on a qualified write, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load_en) begin
            bank_q <= wdata;
        end
    end
endmodule

// File: rtl/bank_out_mask.sv
// Mask: passes the stored bank to the memory address lines only for upper-half accesses.
// Assumes: the top address bit set means paged space, and clear means the common area.
module bank_out_mask #(
    parameter int BANK_W = 4
) (
    input  logic              paged,
    input  logic [BANK_W-1:0] bank_q,
    output logic [BANK_W-1:0] page_addr
);
    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
        // Force each address line low during common-area accesses.
        always_comb begin
            page_addr[i] = bank_q[i] & paged;
        end
    end
endmodule

// File: rtl/bank_switch_latch.sv
// Top: a program bank number loaded through a data write into the top of data space,
// driven onto the upper memory address lines except while the common area is addressed.
// Assumes: cpu_addr_hi carries A15..A5, with its MSB as A15.
module bank_switch_latch #(
    parameter int ADDR_HI_W = bank_switch_pkg::DEF_ADDR_HI_W,
    parameter int BANK_W    = bank_switch_pkg::DEF_BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_HI_W-1:0] cpu_addr_hi,
    input  logic [BANK_W-1:0]    cpu_wdata,
    input  logic                 cpu_wr_n,
    output logic [BANK_W-1:0]    page_addr
);
    localparam int TOP_BIT = ADDR_HI_W - 1;

    logic              load_en;
    logic [BANK_W-1:0] bank_q;

    bank_window_decode #(.ADDR_HI_W(ADDR_HI_W)) u_dec (
        .addr_hi (cpu_addr_hi),
        .wr_n    (cpu_wr_n),
        .load_en (load_en)
    );

    bank_hold_reg #(.BANK_W(BANK_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .wdata   (cpu_wdata),
        .bank_q  (bank_q)
    );

    bank_out_mask #(.BANK_W(BANK_W)) u_mask (
        .paged     (cpu_addr_hi[TOP_BIT]),
        .bank_q    (bank_q),
        .page_addr (page_addr)
    );
endmodule

// File: rtl/bank_switch_latch_chk.sv
// Checker: temporal properties of the bank switch latch, attached by bind.
// Assumes: it sees the top's ports and the stored bank of its register.
module bank_switch_latch_chk #(
    parameter int ADDR_HI_W = 11,
    parameter int BANK_W    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_HI_W-1:0] cpu_addr_hi,
    input logic [BANK_W-1:0]    cpu_wdata,
    input logic                 cpu_wr_n,
    input logic [BANK_W-1:0]    page_addr,
    input logic [BANK_W-1:0]    bank_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> bank_q == '0); // R1
    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr_n && (&cpu_addr_hi)) |=> bank_q == $past(cpu_wdata)); // R2
    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr_n && !(&cpu_addr_hi)) |=> $stable(bank_q)); // R3
    AST_COMMON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr_hi[ADDR_HI_W-1] |-> page_addr == '0); // R4
    AST_PAGED_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr_hi[ADDR_HI_W-1] |-> page_addr == bank_q); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_n |=> $stable(bank_q)); // R6
endmodule

bind bank_switch_latch bank_switch_latch_chk #(
    .ADDR_HI_W(ADDR_HI_W),
    .BANK_W   (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr_hi (cpu_addr_hi),
    .cpu_wdata   (cpu_wdata),
    .cpu_wr_n    (cpu_wr_n),
    .page_addr   (page_addr),
    .bank_q      (bank_q)
);

// File: tb/bank_switch_latch_tb.sv
module bank_switch_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cpu_addr_hi = '0;
    logic [3:0]  cpu_wdata = '0;
    logic        cpu_wr_n = 1'b1;
    logic [3:0]  page_addr;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    bank_switch_latch u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi),
        .cpu_wdata(cpu_wdata), .cpu_wr_n(cpu_wr_n), .page_addr(page_addr)
    );

    // Fields: 16-bit address, write strobe, data, expected page_addr after the edge.
    localparam int NV = 18;
    localparam logic [24:0] VEC [NV] = '{
        {16'hFFFF, 1'b1, 4'h0, 4'h0},  // R5 paged, bank still 0
        {16'hFFE0, 1'b0, 4'h5, 4'h5},  // R2 load 5 at the window base
        {16'h8000, 1'b1, 4'h0, 4'h5},  // R5
        {16'h0123, 1'b1, 4'h0, 4'h0},  // R4 common area
        {16'h7FFF, 1'b1, 4'h0, 4'h0},  // R4
        {16'hC000, 1'b1, 4'h0, 4'h5},  // R5 restored
        {16'hFFDF, 1'b0, 4'hA, 4'h5},  // R3 misses on A5
        {16'h7FE0, 1'b0, 4'h9, 4'h0},  // R3 misses on A15, R4
        {16'h9000, 1'b1, 4'h0, 4'h5},  // R3 bank unchanged
        {16'hFFF0, 1'b1, 4'h7, 4'h5},  // R6 strobe high
        {16'hFFFF, 1'b0, 4'hC, 4'hC},  // R2 load at the window top
        {16'h0000, 1'b1, 4'h0, 4'h0},  // R4
        {16'hFFFF, 1'b1, 4'h0, 4'hC},  // R5
        {16'hFFE5, 1'b0, 4'h0, 4'h0},  // R2 load 0
        {16'h8001, 1'b1, 4'h0, 4'h0},  // R5 bank 0
        {16'hFFE0, 1'b0, 4'hF, 4'hF},  // R2 load F
        {16'h0040, 1'b0, 4'h3, 4'h0},  // R3 common write misses
        {16'hA000, 1'b1, 4'h0, 4'hF}   // R5 restored F
    };

    task automatic check(input logic [3:0] exp, input string req);
        n_chk++;
        if (page_addr !== exp) begin
            n_bad++;
            $display("FAIL %s: page_addr=%h expected=%h", req, page_addr, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic w, input logic [3:0] d);
        @(negedge clk);
        cpu_addr_hi = a[15:5];
        cpu_wr_n    = w;
        cpu_wdata   = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        // R1 reset state seen on a paged address
        cpu_addr_hi = 11'h7FF;
        repeat (3) @(posedge clk);
        #2;
        check(4'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][24:9], VEC[i][8], VEC[i][7:4]);
            check(VEC[i][3:0], $sformatf("vector %0d", i));
        end
        // R7 long idle holds the bank
        for (int i = 0; i < 20; i++) drive(16'hB000, 1'b1, 4'h2);
        check(4'hF, "R7");
        // R6 strobe high across the whole window with data changing
        for (int i = 0; i < 32; i++) drive(16'hFFE0 + 16'(i), 1'b1, 4'(i));
        check(4'hF, "R6");
        // R2 back-to-back loads: the last one wins
        drive(16'hFFE1, 1'b0, 4'h6);
        drive(16'hFFE2, 1'b0, 4'h3);
        drive(16'h8000, 1'b1, 4'h0);
        check(4'h3, "R2");
        // R1 reset in mid-run clears the bank
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        @(negedge clk);
        rst_n = 1'b1;
        cpu_addr_hi = 11'h7FF;
        cpu_wr_n = 1'b1;
        #1;
        check(4'h0, "R1");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule